// File: doc/BRIEF.md
# Gated Three-Controller JTAG Scan Chain

This block joins three boundary-scan test access controllers in series behind one set of JTAG pins. All three share TCK, TMS and the asynchronous TRST, so their state machines move in lockstep. From TDI the order is: the primary controller, then the secondary controller, then the debug controller, whose output drives TDO. The primary controller owns a 32-bit control register. The low two bits of that register switch the other two controllers into the data path.

After reset only the primary controller is fully live. The debug controller answers every data scan as a single bypass bit. The secondary controller still takes part in every instruction scan, but it adds no bits to data scans. The primary and secondary controllers both accept a skip instruction that removes their own data register from the data path. A host can therefore aim a 32-bit data scan at the control register alone. The pins carry no valid/ready handshake: the host paces every bit with TCK, so there is no back-pressure to manage.

Top module: `tap_chain3`

## Requirements
- R1: An instruction scan is 16 bits. The first 4 bits out of TDO are the debug controller's instruction register, the next 6 are the secondary's and the last 6 are the primary's. Bits shifted in are loaded the same way: bits [3:0] of the word go to debug, [9:4] to secondary and [15:10] to primary. During Capture-IR each register loads the value 1, so the first bit out of each is 1 and the rest are 0.
- R2: After reset the data path is 33 bits long: one bypass bit for debug, nothing for secondary, and the primary's 32-bit identity register.
- R3: The identity instruction is 0x09 in the primary and secondary controllers and 0xE in the debug controller. It selects a 32-bit register that captures the parameter values ID_PRI, ID_SEC and ID_DBG.
- R4: The all-ones code, and any code not listed in R3, R5 or R6, selects a 1-bit bypass register that captures 0. This includes code 0x20 in the secondary controller.
- R5: Code 0x20 in the primary controller selects the 32-bit control register. Capture-DR reads its present value and Update-DR writes it. Bit 0 enables the secondary controller and bit 1 enables the debug controller. Enables change only on Update-DR or in Test-Logic-Reset.
- R6: Code 0x24 in the primary or secondary controller makes that controller add zero bits to data scans.
- R7: While the secondary controller is disabled, it adds zero bits to data scans whatever its instruction. While the debug controller is disabled, it adds one bypass bit whatever its instruction. Both instruction registers stay in the instruction path.
- R8: Test-Logic-Reset, reached either through TRST low or through five TCK cycles with TMS high, sets every instruction register to its identity code and clears the control register.
- R9: Registers shift least significant bit first. TDO changes only on the falling edge of TCK and is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data into the primary controller |
| tdo | output | 1 | Serial data out of the debug controller, updated on falling TCK |

## Verification
Each register loads on the rising edge that leaves a Capture state. Its first bit appears on TDO at the next falling edge, and each later bit appears one full TCK period after the one before it. The bench therefore drives TMS and TDI 1 ns after each falling edge and reads TDO in that same window, before the rising edge that shifts the chain. A queue model of the chain in the bench predicts every TDO bit of every scan. The model applies new instructions and enables only after the Update cycle of a scan, so path-length and identity checks always use the configuration set by the previous scan.

// File: rtl/tapc_pkg.sv
`timescale 1ns/1ps
package tapc_pkg;
  localparam int DR_W       = 32;
  localparam int EN_SEC_BIT = 0;
  localparam int EN_DBG_BIT = 1;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DM_NONE, DM_BYP, DM_ID, DM_REG} dr_mode_e;

  localparam logic [5:0] WIDE_IDCODE   = 6'h09;
  localparam logic [5:0] WIDE_CTRL     = 6'h20;
  localparam logic [5:0] WIDE_SKIP     = 6'h24;
  localparam logic [3:0] NARROW_IDCODE = 4'hE;
endpackage

// File: rtl/tapc_fsm.sv
`timescale 1ns/1ps
module tapc_fsm
  import tapc_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    unique case (state)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      default:   nxt = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= nxt;
  end

  assert_tlr_hold_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET && tms) |=> (state == TS_RESET));
endmodule

// File: rtl/tapc_port.sv
`timescale 1ns/1ps
module tapc_port
  import tapc_pkg::*;
#(
  parameter int              IR_W       = 6,
  parameter logic [DR_W-1:0] ID_VAL     = 32'h0000_0001,
  parameter logic [IR_W-1:0] IR_ID      = '0,
  parameter bit              HAS_CTRL   = 1'b0,
  parameter logic [IR_W-1:0] CTRL_CODE  = '0,
  parameter bit              HAS_SKIP   = 1'b0,
  parameter logic [IR_W-1:0] SKIP_CODE  = '0,
  parameter bit              OFF_BYPASS = 1'b0
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            si,
  input  logic            en,
  output logic            so,
  output tap_state_e      state_o,
  output logic [DR_W-1:0] ctrl_o
);
  localparam logic [IR_W-1:0] IR_CAP = IR_W'(1);

  tap_state_e      state;
  logic [IR_W-1:0] ir, ir_sr;
  logic [DR_W-1:0] dr_sr, ctrl_q;
  logic            byp_q;
  dr_mode_e        mode;

  tapc_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  always_comb begin
    if (!en)                                   mode = OFF_BYPASS ? DM_BYP : DM_NONE;
    else if (ir == IR_ID)                      mode = DM_ID;
    else if (HAS_CTRL && ir == CTRL_CODE)      mode = DM_REG;
    else if (HAS_SKIP && ir == SKIP_CODE)      mode = DM_NONE;
    else                                       mode = DM_BYP;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir    <= IR_ID;
      ir_sr <= '0;
      dr_sr <= '0;
      byp_q <= 1'b0;
    end else begin
      case (state)
        TS_RESET:  ir    <= IR_ID;
        TS_CAP_IR: ir_sr <= IR_CAP;
        TS_SH_IR:  ir_sr <= {si, ir_sr[IR_W-1:1]};
        TS_UPD_IR: ir    <= ir_sr;
        TS_CAP_DR: begin
          dr_sr <= (mode == DM_REG) ? ctrl_q : ID_VAL;
          byp_q <= 1'b0;
        end
        TS_SH_DR: begin
          dr_sr <= {si, dr_sr[DR_W-1:1]};
          byp_q <= si;
        end
        default: ;
      endcase
    end
  end

  generate
    if (HAS_CTRL) begin : g_ctrl
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                                  ctrl_q <= '0;
        else if (state == TS_RESET)                   ctrl_q <= '0;
        else if (state == TS_UPD_DR && mode == DM_REG) ctrl_q <= dr_sr;
      end

      assert_ctrl_stable_R5: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == TS_UPD_DR || state == TS_RESET) |=> $stable(ctrl_q));
    end else begin : g_noctrl
      assign ctrl_q = '0;
    end
  endgenerate

  always_comb begin
    if (state == TS_SH_IR) so = ir_sr[0];
    else begin
      case (mode)
        DM_NONE: so = si;
        DM_BYP:  so = byp_q;
        default: so = dr_sr[0];
      endcase
    end
  end

  assign state_o = state;
  assign ctrl_o  = ctrl_q;

  assert_ir_capture_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

  assert_ir_reset_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET) |=> (ir == IR_ID));

  assert_off_bypass_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (OFF_BYPASS && !en && state == TS_SH_DR) |=> (so == $past(si)));

  assert_off_absent_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (!OFF_BYPASS && !en && state == TS_SH_DR) |-> (so == si));
endmodule

// File: rtl/tap_chain3.sv
`timescale 1ns/1ps
module tap_chain3
  import tapc_pkg::*;
#(
  parameter logic [DR_W-1:0] ID_PRI = 32'h0BA1_1093,
  parameter logic [DR_W-1:0] ID_SEC = 32'h0BA2_2093,
  parameter logic [DR_W-1:0] ID_DBG = 32'h4BA0_0477
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo
);
  logic            pri_so, sec_so, dbg_so;
  logic            en_sec, en_dbg;
  logic [DR_W-1:0] pri_ctrl, sec_ctrl_unused, dbg_ctrl_unused;
  logic            ctrl_hi_unused;
  tap_state_e      pri_state, sec_state, dbg_state;

  tapc_port #(
    .IR_W(6), .ID_VAL(ID_PRI), .IR_ID(WIDE_IDCODE),
    .HAS_CTRL(1'b1), .CTRL_CODE(WIDE_CTRL),
    .HAS_SKIP(1'b1), .SKIP_CODE(WIDE_SKIP), .OFF_BYPASS(1'b0)
  ) u_pri (
    .tck(tck), .trst_n(trst_n), .tms(tms), .si(tdi), .en(1'b1),
    .so(pri_so), .state_o(pri_state), .ctrl_o(pri_ctrl)
  );

  tapc_port #(
    .IR_W(6), .ID_VAL(ID_SEC), .IR_ID(WIDE_IDCODE),
    .HAS_CTRL(1'b0), .CTRL_CODE(6'h00),
    .HAS_SKIP(1'b1), .SKIP_CODE(WIDE_SKIP), .OFF_BYPASS(1'b0)
  ) u_sec (
    .tck(tck), .trst_n(trst_n), .tms(tms), .si(pri_so), .en(en_sec),
    .so(sec_so), .state_o(sec_state), .ctrl_o(sec_ctrl_unused)
  );

  tapc_port #(
    .IR_W(4), .ID_VAL(ID_DBG), .IR_ID(NARROW_IDCODE),
    .HAS_CTRL(1'b0), .CTRL_CODE(4'h0),
    .HAS_SKIP(1'b0), .SKIP_CODE(4'h0), .OFF_BYPASS(1'b1)
  ) u_dbg (
    .tck(tck), .trst_n(trst_n), .tms(tms), .si(sec_so), .en(en_dbg),
    .so(dbg_so), .state_o(dbg_state), .ctrl_o(dbg_ctrl_unused)
  );

  assign en_sec         = pri_ctrl[EN_SEC_BIT];
  assign en_dbg         = pri_ctrl[EN_DBG_BIT];
  assign ctrl_hi_unused = ^pri_ctrl[DR_W-1:2];

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo <= 1'b0;
    else         tdo <= dbg_so;
  end

  assert_lockstep_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (pri_state == sec_state) && (sec_state == dbg_state));

  assert_en_timing_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (!$stable(en_sec) || !$stable(en_dbg)) |->
      ($past(pri_state) == TS_UPD_DR || $past(pri_state) == TS_RESET));
endmodule

// File: tb/tap_chain3_tb.sv
`timescale 1ns/1ps
module tap_chain3_tb;
  localparam logic [31:0] ID_P = 32'h0BA1_1093;
  localparam logic [31:0] ID_S = 32'h0BA2_2093;
  localparam logic [31:0] ID_D = 32'h4BA0_0477;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo;
  int checks = 0, errors = 0, bad_edges = 0;
  bit mq[$];
  logic [5:0]  m_ir_p, m_ir_s;
  logic [3:0]  m_ir_d;
  logic [31:0] m_ctrl;

  tap_chain3 #(.ID_PRI(ID_P), .ID_SEC(ID_S), .ID_DBG(ID_D)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo));

  always #2 tck = ~tck;

  // R9: TDO may only move while TCK is low (falling edge update)
  always @(tdo) if (trst_n === 1'b1 && tck !== 1'b0) bad_edges++;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    tms = m; tdi = d; o = tdo;
    @(posedge tck);
  endtask

  task automatic m_reset();
    m_ir_p = 6'h09; m_ir_s = 6'h09; m_ir_d = 4'hE; m_ctrl = '0;
  endtask

  task automatic push(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) mq.push_back(v[i]);
  endtask

  task automatic build_dr();
    mq.delete();
    if (!m_ctrl[1])           push(0, 1);
    else if (m_ir_d == 4'hE)  push(ID_D, 32);
    else                      push(0, 1);
    if (m_ctrl[0]) begin
      if (m_ir_s == 6'h09)      push(ID_S, 32);
      else if (m_ir_s != 6'h24) push(0, 1);
    end
    if (m_ir_p == 6'h09)      push(ID_P, 32);
    else if (m_ir_p == 6'h20) push(m_ctrl, 32);
    else if (m_ir_p != 6'h24) push(0, 1);
  endtask

  task automatic ir_scan(input logic [15:0] val, output logic [15:0] got);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    mq.delete();
    push(1, 4); push(1, 6); push(1, 6);
    for (int i = 0; i < 16; i++) begin
      step(i == 15, val[i], o);
      got[i] = o;
      chk("R1 IR serial bit", o, mq[0]);
      void'(mq.pop_front());
      mq.push_back(val[i]);
    end
    step(1, 0, o); step(0, 0, o);
    m_ir_d = val[3:0]; m_ir_s = val[9:4]; m_ir_p = val[15:10];
  endtask

  task automatic dr_scan(input int n, input logic [255:0] val, output logic [255:0] got);
    logic o;
    int len;
    got = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    build_dr();
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, val[i], o);
      got[i] = o;
      chk("R9 DR serial bit", o, mq[0]);
      void'(mq.pop_front());
      mq.push_back(val[i]);
    end
    step(1, 0, o); step(0, 0, o);
    if (m_ir_p == 6'h20) begin
      len = mq.size();
      for (int i = 0; i < 32; i++) m_ctrl[i] = mq[len - 32 + i];
    end
  endtask

  task automatic dr_len(output int len);
    logic [255:0] got;
    dr_scan(200, 256'b1 << 100, got);
    len = -1;
    for (int k = 199; k >= 100; k--) if (got[k]) len = k - 100;
  endtask

  task automatic soft_reset();
    logic o;
    for (int i = 0; i < 5; i++) step(1, 0, o);
    step(0, 0, o);
    m_reset();
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0]  ig;
    logic [255:0] dg;
    logic         o;
    int           len;
    m_reset();
    #9;
    chk("R9 tdo low in reset", tdo, 1'b0);
    trst_n = 1'b1;
    step(0, 0, o);

    // R2: reset path length and contents
    dr_len(len);
    chk("R2 reset DR length", len, 33);
    dr_scan(33, '0, dg);
    chk("R3 primary IDCODE", dg[32:1], ID_P);
    chk("R7 debug off bypass captures 0", dg[0], 1'b0);

    // R1 / R4: all-ones instructions
    ir_scan(16'hFFFF, ig);
    chk("R1 IR capture pattern", ig, 16'h0411);
    dr_len(len);
    chk("R4 bypass length", len, 2);

    // R5: enable via control register behind skipped secondary
    ir_scan(16'h824F, ig);
    dr_scan(33, 256'h6, dg);
    chk("R5 ctrl capture initial", dg[32:1], 32'h0);

    // R3: all identity registers
    ir_scan(16'h249E, ig);
    dr_len(len);
    chk("R5 enabled DR length", len, 96);
    dr_scan(96, '0, dg);
    chk("R3 debug IDCODE", dg[31:0], ID_D);
    chk("R3 secondary IDCODE", dg[63:32], ID_S);
    chk("R3 primary IDCODE all on", dg[95:64], ID_P);

    // R6: primary skipped
    ir_scan(16'h909F, ig);
    dr_len(len);
    chk("R6 primary skip length", len, 33);
    dr_scan(33, '0, dg);
    chk("R6 secondary IDCODE behind skip", dg[32:1], ID_S);

    // R6: both skipped
    ir_scan(16'h924E, ig);
    dr_len(len);
    chk("R6 both skip length", len, 32);
    dr_scan(32, '0, dg);
    chk("R6 debug IDCODE alone", dg[31:0], ID_D);

    // R5 / R7: disable debug
    ir_scan(16'h83FF, ig);
    dr_scan(34, 256'h4, dg);
    chk("R5 ctrl capture readback", dg[33:2], 32'h3);
    ir_scan(16'h249E, ig);
    dr_len(len);
    chk("R7 debug off length", len, 65);

    // R7: disable secondary, enable debug
    ir_scan(16'h83FF, ig);
    dr_scan(34, 256'h8, dg);
    chk("R5 ctrl readback 1", dg[33:2], 32'h1);
    ir_scan(16'h249E, ig);
    dr_len(len);
    chk("R7 secondary off length", len, 64);

    // R4: unlisted codes
    ir_scan(16'h57F3, ig);
    dr_len(len);
    chk("R4 unlisted code length", len, 2);

    // R8: TMS reset clears control and instructions
    soft_reset();
    dr_len(len);
    chk("R8 soft reset length", len, 33);
    dr_scan(33, '0, dg);
    chk("R8 IR back to IDCODE", dg[32:1], ID_P);

    chk("R9 tdo only on falling edge", bad_edges, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule